// File: doc/BRIEF.md
# DMA Request Router and Channel Priority Arbiter

This block sits between the peripheral DMA request wires and a bank of DMA channel engines. Each request line owns a small map entry. The entry holds a valid flag and the number of a target channel. When the flag is set, that line's request is steered to the target channel. Several lines may point at one channel, and their requests then merge into one.

Among channels that are both running and requesting, a fixed four-level priority scheme picks one channel for the shared memory port. A channel's level comes from its index. The grant is held until the current burst reports completion.

The block also folds each channel's status-interrupt bits into a one-bit-per-channel summary word. Software scans that word to find the channels that need service.

Top module: `chan_req_arbiter`

## Requirements
- R1: A map write (`map_we` high at a clock edge) stores bit 7 of `map_wdata` as the valid flag and bits 4:0 as the target channel for line `map_line`. Bits 6:5 are ignored. The new mapping routes requests from the next cycle on.
- R2: A request line whose valid flag is clear drives no channel request. Writing 8'h00, or any value with bit 7 clear, unmaps the line.
- R3: `ch_req[c]` is the OR of the requests on all valid lines mapped to channel c, with no clock delay.
- R4: When no grant is held, the candidates are `ch_req & ch_run`. If any candidate exists, the next cycle shows `gnt_valid`=1 with `gnt_ch` set to the winner. If none exists, `gnt_valid` stays 0.
- R5: A channel's priority level is (index mod 16)/4, and level 0 is highest. Channels 0–3 and 16–19 are level 0, 4–7 and 20–23 are level 1, 8–11 and 24–27 are level 2, and 12–15 and 28–31 are level 3.
- R6: Among candidates on the same level, the lowest channel index wins.
- R7: A held grant keeps its channel unchanged, even if higher-priority requests arrive, until `burst_done` is high at a clock edge. At that edge a fresh arbitration result is loaded, which may be no grant.
- R8: A channel that is requesting but whose `ch_run` bit is 0 is never granted.
- R9: `irq_sum[c]` is, one cycle later, the OR of channel c's `STAT_W` status bits. It clears on its own once those bits are cleared.
- R10: After reset every line is unmapped, no grant is held and `irq_sum` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| map_we | input | 1 | Map entry write strobe |
| map_line | input | LINE_W | Request line whose map entry is written |
| map_wdata | input | 8 | Map entry value: bit 7 valid, bits 4:0 channel |
| line_req | input | NUM_LINES | Peripheral request lines |
| ch_run | input | NUM_CH | Channel running flags |
| burst_done | input | 1 | Current granted burst completes |
| ch_stat | input | NUM_CH*STAT_W | Per-channel status interrupt bits |
| ch_req | output | NUM_CH | Routed request per channel |
| gnt_valid | output | 1 | A channel holds the memory port |
| gnt_ch | output | CH_W | Granted channel index |
| irq_sum | output | NUM_CH | Per-channel pending interrupt summary |

## Verification
The arbitration is tried with request pairs and triples drawn from one level across both halves of the channel space, which separates lowest-index ordering from level ordering. It is also tried with pairs from different levels where the higher index has the better level, which exposes any plain lowest-index picker. Requests from stopped channels show whether the running mask is applied. A higher-priority request raised during a held burst shows whether the grant is preempted. Routing is tried with reserved bits set, with two lines merged onto one channel, and with lines unmapped by a zero write and by a write with the valid flag clear.

// File: rtl/chan_req_arbiter.sv
module chan_req_arbiter #(
  parameter int NUM_CH    = 32,
  parameter int NUM_LINES = 64,
  parameter int STAT_W    = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        map_we,
  input  logic [$clog2(NUM_LINES)-1:0] map_line,
  input  logic [7:0]                  map_wdata,
  input  logic [NUM_LINES-1:0]        line_req,
  input  logic [NUM_CH-1:0]           ch_run,
  input  logic                        burst_done,
  input  logic [NUM_CH*STAT_W-1:0]    ch_stat,
  output logic [NUM_CH-1:0]           ch_req,
  output logic                        gnt_valid,
  output logic [$clog2(NUM_CH)-1:0]   gnt_ch,
  output logic [NUM_CH-1:0]           irq_sum
);
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int FLD_W  = 5;
  localparam int LEVELS = 4;

  logic [NUM_LINES-1:0] map_vld;
  logic [FLD_W-1:0]     map_ch [NUM_LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_vld <= '0;
      for (int l = 0; l < NUM_LINES; l++) map_ch[l] <= '0;
    end else if (map_we) begin
      map_vld[map_line] <= map_wdata[7];
      map_ch[map_line]  <= map_wdata[FLD_W-1:0];
    end
  end

  always_comb begin
    ch_req = '0;
    for (int l = 0; l < NUM_LINES; l++)
      if (map_vld[l] && line_req[l] && (int'(map_ch[l]) < NUM_CH))
        ch_req[map_ch[l][CH_W-1:0]] = 1'b1;
  end

  logic [NUM_CH-1:0] cand;
  logic              pick_found;
  logic [CH_W-1:0]   pick_ch;

  assign cand = ch_req & ch_run;

  always_comb begin
    pick_found = 1'b0;
    pick_ch    = '0;
    for (int lvl = 0; lvl < LEVELS; lvl++)
      for (int i = 0; i < NUM_CH; i++)
        if (!pick_found && cand[i] && ((i % 16) / 4) == lvl) begin
          pick_found = 1'b1;
          pick_ch    = CH_W'(i);
        end
  end

  wire rearb = !gnt_valid || burst_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_valid <= 1'b0;
      gnt_ch    <= '0;
    end else if (rearb) begin
      gnt_valid <= pick_found;
      gnt_ch    <= pick_ch;
    end
  end

  logic [NUM_CH-1:0] stat_or;
  always_comb
    for (int c = 0; c < NUM_CH; c++) stat_or[c] = |ch_stat[c*STAT_W +: STAT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_sum <= '0;
    else        irq_sum <= stat_or;
  end

  a_r2_unmapped_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (map_vld == '0) |-> (ch_req == '0));

  a_r7_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !burst_done) |=> (gnt_valid && $stable(gnt_ch)));

  a_r4_no_cand_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (rearb && cand == '0) |=> !gnt_valid);

  a_r8_grant_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    (rearb && cand != '0) |=> (gnt_valid && (($past(cand) >> gnt_ch) & NUM_CH'(1)) != '0));

  a_r9_sum_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_stat == '0) |=> (irq_sum == '0));
endmodule

// File: tb/test_chan_req_arbiter.sv
module test_chan_req_arbiter;
  localparam int NUM_CH = 32, NUM_LINES = 64, STAT_W = 3;

  logic clk = 0, rst_n = 0;
  logic map_we = 0;
  logic [5:0] map_line = '0;
  logic [7:0] map_wdata = '0;
  logic [NUM_LINES-1:0] line_req = '0;
  logic [NUM_CH-1:0] ch_run = '0;
  logic burst_done = 0;
  logic [NUM_CH*STAT_W-1:0] ch_stat = '0;
  logic [NUM_CH-1:0] ch_req, irq_sum;
  logic gnt_valid;
  logic [4:0] gnt_ch;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  chan_req_arbiter #(.NUM_CH(NUM_CH), .NUM_LINES(NUM_LINES), .STAT_W(STAT_W)) i_chan_req_arbiter (
    .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_line(map_line), .map_wdata(map_wdata),
    .line_req(line_req), .ch_run(ch_run), .burst_done(burst_done), .ch_stat(ch_stat),
    .ch_req(ch_req), .gnt_valid(gnt_valid), .gnt_ch(gnt_ch), .irq_sum(irq_sum));

  // {requests on lines 31:0, ch_run, expected valid, expected channel}
  localparam logic [69:0] VEC [10] = '{
    {32'h0010_0020, 32'hFFFF_FFFF, 1'b1, 5'd5},
    {32'h0002_0008, 32'hFFFF_FFFF, 1'b1, 5'd3},
    {32'h0002_0200, 32'hFFFF_FFFF, 1'b1, 5'd17},
    {32'h8000_1000, 32'hFFFF_FFFF, 1'b1, 5'd12},
    {32'h4000_0010, 32'hFFFF_FFFF, 1'b1, 5'd4},
    {32'h0000_0004, 32'hFFFF_FFFB, 1'b0, 5'd0},
    {32'h0004_0004, 32'hFFFF_FFFB, 1'b1, 5'd18},
    {32'h0000_0000, 32'hFFFF_FFFF, 1'b0, 5'd0},
    {32'h1100_0100, 32'hFFFF_FFFF, 1'b1, 5'd8},
    {32'h0080_8000, 32'hFFFF_FFFF, 1'b1, 5'd23}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic map_write(input int line, input logic [7:0] val);
    map_we = 1; map_line = 6'(line); map_wdata = val;
    tick();
    map_we = 0;
  endtask

  task automatic release_grant();
    line_req = '0; burst_done = 1;
    tick();
    burst_done = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    line_req = '1;
    ch_run = '1;
    @(negedge clk); @(negedge clk);
    chk("R10 reset gnt_valid", 64'(gnt_valid), 64'd0);
    chk("R10 reset irq_sum", 64'(irq_sum), 64'd0);
    chk("R10/R2 reset unmapped ch_req", 64'(ch_req), 64'd0);
    rst_n = 1;
    line_req = '0;
    tick();
    chk("R10 no grant without mapping", 64'(gnt_valid), 64'd0);

    for (int i = 0; i < 32; i++) map_write(i, 8'h80 | 8'(i));

    foreach (VEC[k]) begin
      line_req = {32'h0, VEC[k][69:38]};
      ch_run = VEC[k][37:6];
      tick();
      chk($sformatf("R4/R5/R6/R8 vec%0d valid", k), 64'(gnt_valid), 64'(VEC[k][5]));
      if (VEC[k][5]) chk($sformatf("R5/R6 vec%0d channel", k), 64'(gnt_ch), 64'(VEC[k][4:0]));
      release_grant();
    end
    ch_run = '1;

    // R1: reserved bits ignored, line 40 -> channel 7
    map_write(40, 8'hE7);
    line_req = '0; line_req[40] = 1;
    #1 chk("R1 remap line 40 to ch 7", 64'(ch_req), 64'(32'h80));
    line_req[7] = 1;
    #1 chk("R3 two lines merge on ch 7", 64'(ch_req), 64'(32'h80));
    line_req[40] = 0;
    #1 chk("R3 one of merged lines drops", 64'(ch_req), 64'(32'h80));
    release_grant();
    release_grant();

    // R2: unmap by zero write and by valid-clear write
    map_write(40, 8'h00);
    line_req = '0; line_req[40] = 1;
    #1 chk("R2 zero write unmaps", 64'(ch_req), 64'd0);
    map_write(40, 8'h07);
    #1 chk("R2 valid clear ignored", 64'(ch_req), 64'd0);
    tick();
    chk("R2 unmapped line gives no grant", 64'(gnt_valid), 64'd0);
    line_req = '0;

    // R7: hold against higher priority, re-arbitrate on burst_done
    line_req[20] = 1;
    tick();
    chk("R7 grant ch 20", 64'(gnt_ch), 64'd20);
    line_req[1] = 1;
    tick(); tick();
    chk("R7 grant held valid", 64'(gnt_valid), 64'd1);
    chk("R7 grant held on ch 20", 64'(gnt_ch), 64'd20);
    burst_done = 1;
    tick();
    burst_done = 0;
    chk("R7 re-arbitrate to ch 1", 64'(gnt_ch), 64'd1);
    release_grant();
    chk("R7 release leaves no grant", 64'(gnt_valid), 64'd0);

    // R9: interrupt summary
    ch_stat[3*STAT_W + 2] = 1;
    #1 chk("R9 summary waits a cycle", 64'(irq_sum), 64'd0);
    tick();
    chk("R9 summary ch 3", 64'(irq_sum), 64'(32'h8));
    ch_stat[0] = 1;
    ch_stat[31*STAT_W + 1] = 1;
    tick();
    chk("R9 summary ch 0,3,31", 64'(irq_sum), 64'(32'h8000_0009));
    ch_stat[3*STAT_W + 2] = 0;
    tick();
    chk("R9 summary ch 3 clears", 64'(irq_sum), 64'(32'h8000_0001));
    ch_stat = '0;
    tick();
    chk("R9 summary all clear", 64'(irq_sum), 64'd0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule